// File: doc/BRIEF.md
# SECDED-Protected Word Memory with Run-Time Bypass

This block is a synchronous single-port RAM that guards each 32-bit word with a single-error-correct, double-error-detect code. Every stored word holds 32 data bits and 7 check bits. The check bits are six Hamming bits at the power-of-two codeword positions 1, 2, 4, 8, 16 and 32, plus one overall parity bit. A read request returns the word one clock later. When protection is on, the read corrects a single flipped bit, flags a double flip, and updates saturating event counters.

Protection can be switched off at run time with `prot_en`. A write made while protection is off replaces only the data bits and leaves the old check bits in place. A test sequence can therefore plant one-bit or two-bit faults, turn protection back on, and watch the block detect, correct and count them. Reads made while protection is off return the stored bits unchanged, with no checking.

Top module: `ecc_mem`

## Requirements
- R1: A write with `prot_en`=1 stores the data together with freshly computed check bits. A later protected read of that address returns the same data with `sec_err`=0 and `ded_err`=0.
- R2: A protected read of a word with exactly one data bit flipped returns the originally written data. It also pulses `sec_err` and `irq` high for one cycle.
- R3: A protected read of a word with exactly two data bits flipped returns the raw stored data. It pulses `ded_err` and `irq` high for one cycle, with `sec_err` low.
- R4: Each protected read that flags a one-bit error adds one to `sec_cnt`. Each protected read that flags a two-bit error adds one to `ded_cnt`. The two counters never affect each other.
- R5: Both counters saturate at 2^CW-1 and never wrap.
- R6: A write with `prot_en`=0 changes only the data bits and keeps the previously stored check bits.
- R7: A read with `prot_en`=0 returns the raw stored data. It drives no `sec_err`, `ded_err` or `irq`, and leaves the counters and captured addresses unchanged.
- R8: Reset (`rst_n`=0) and a synchronous `clr` pulse set both counters and both captured addresses to zero.
- R9: `sec_addr` and `ded_addr` hold the address of the most recent protected read that flagged a one-bit error and a two-bit error, respectively.
- R10: `rvalid`, `rdata`, the error flags and the counter and address updates all appear exactly one cycle after a read request (`req`=1, `we`=0). `rvalid` stays low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and captured addresses |
| prot_en | input | 1 | Protection enable, sampled with each request |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data, corrected when possible |
| sec_err | output | 1 | One-bit error pulse |
| ded_err | output | 1 | Two-bit error pulse |
| irq | output | 1 | Interrupt pulse on any detected error |
| sec_cnt | output | CW | One-bit error counter |
| ded_cnt | output | CW | Two-bit error counter |
| sec_addr | output | AW | Address of the latest one-bit error |
| ded_addr | output | AW | Address of the latest two-bit error |

## Verification
Every read result is due on the first rising edge after the request: the data, the three pulses, the counter increment and the address capture. A write produces no result at all. The driver raises a request on a falling edge and records the expected word and flags in a queue. The monitor compares them on the next falling edge, while `rvalid` is high. Counters and captured addresses are compared on that same falling edge, once the read has fully settled. An `rvalid` that arrives with no pending expectation counts as a failure.

// File: rtl/ecc_mem.sv
module ecc_mem #(
  parameter int AW = 6,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          prot_en,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          rvalid,
  output logic [31:0]   rdata,
  output logic          sec_err,
  output logic          ded_err,
  output logic          irq,
  output logic [CW-1:0] sec_cnt,
  output logic [CW-1:0] ded_cnt,
  output logic [AW-1:0] sec_addr,
  output logic [AW-1:0] ded_addr
);
  localparam int DW    = 32;
  localparam int HB    = 6;
  localparam int NPOS  = DW + HB;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [HB-1:0] hcalc(input logic [DW-1:0] d);
    logic [HB-1:0] h;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < HB; k++)
          if (((p >> k) & 1) == 1) h[k] = h[k] ^ d[j];
        j++;
      end
    end
    return h;
  endfunction

  function automatic logic [DW-1:0] fix(input logic [DW-1:0] d, input logic [HB-1:0] s);
    logic [DW-1:0] r;
    int j;
    r = d;
    j = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (int'(s) == p) r[j] = ~d[j];
        j++;
      end
    end
    return r;
  endfunction

  logic [DW-1:0] dmem [DEPTH];
  logic [HB:0]   cmem [DEPTH];

  logic [DW-1:0] raw;
  logic [HB:0]   chk;
  logic [HB-1:0] syn;
  logic          par, one, two, rd, prd;
  logic [HB-1:0] wh;

  assign raw = dmem[addr];
  assign chk = cmem[addr];
  assign syn = chk[HB-1:0] ^ hcalc(raw);
  assign par = chk[HB] ^ (^raw) ^ (^chk[HB-1:0]);
  assign one = par && (int'(syn) <= NPOS);
  assign two = (!par && syn != '0) || (par && int'(syn) > NPOS);
  assign rd  = req && !we;
  assign prd = rd && prot_en;
  assign wh  = hcalc(wdata);

  always_ff @(posedge clk) begin
    if (req && we) begin
      dmem[addr] <= wdata;
      if (prot_en) cmem[addr] <= {(^wdata) ^ (^wh), wh};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid   <= 1'b0;
      rdata    <= '0;
      sec_err  <= 1'b0;
      ded_err  <= 1'b0;
      irq      <= 1'b0;
      sec_cnt  <= '0;
      ded_cnt  <= '0;
      sec_addr <= '0;
      ded_addr <= '0;
    end else begin
      rvalid  <= rd;
      sec_err <= prd && one;
      ded_err <= prd && two;
      irq     <= prd && (one || two);
      if (rd) rdata <= (prd && one) ? fix(raw, syn) : raw;
      if (clr) begin
        sec_cnt  <= '0;
        ded_cnt  <= '0;
        sec_addr <= '0;
        ded_addr <= '0;
      end else begin
        if (prd && one) begin
          sec_addr <= addr;
          if (sec_cnt != CMAX) sec_cnt <= sec_cnt + 1'b1;
        end
        if (prd && two) begin
          ded_addr <= addr;
          if (ded_cnt != CMAX) ded_cnt <= ded_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ecc_mem_chk.sv
module ecc_mem_chk #(
  parameter int AW = 6,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          prot_en,
  input logic          req,
  input logic          we,
  input logic          rvalid,
  input logic          sec_err,
  input logic          ded_err,
  input logic          irq,
  input logic [CW-1:0] sec_cnt,
  input logic [CW-1:0] ded_cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  assert_valid_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);
  assert_no_valid_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_err && ded_err));
  assert_irq_on_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_err || ded_err) |-> (irq && rvalid));
  assert_bypass_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !prot_en) |=> (!sec_err && !ded_err && !irq));
  assert_sec_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && sec_err) |-> sec_cnt == (($past(sec_cnt) == CMAX) ? CMAX : $past(sec_cnt) + 1'b1));
  assert_ded_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && ded_err) |-> ded_cnt == (($past(ded_cnt) == CMAX) ? CMAX : $past(ded_cnt) + 1'b1));
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_cnt == CMAX && !clr) |=> sec_cnt == CMAX);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sec_cnt == '0 && ded_cnt == '0));
endmodule

bind ecc_mem ecc_mem_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .prot_en(prot_en), .req(req), .we(we),
  .rvalid(rvalid), .sec_err(sec_err), .ded_err(ded_err), .irq(irq),
  .sec_cnt(sec_cnt), .ded_cnt(ded_cnt)
);

// File: tb/tb_ecc_mem.sv
module tb_ecc_mem;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, clr = 0, prot_en = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid, sec_err, ded_err, irq;
  logic [31:0] rdata;
  logic [CW-1:0] sec_cnt, ded_cnt;
  logic [AW-1:0] sec_addr, ded_addr;

  ecc_mem #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .prot_en(prot_en), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rvalid(rvalid), .rdata(rdata), .sec_err(sec_err),
    .ded_err(ded_err), .irq(irq), .sec_cnt(sec_cnt), .ded_cnt(ded_cnt),
    .sec_addr(sec_addr), .ded_addr(ded_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [31:0] d;
    logic        s;
    logic        e;
  } item_t;
  item_t sb[$];

  int checks = 0, errors = 0, exp_sc = 0, exp_dc = 0, exp_sa = 0, exp_da = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      item_t it;
      if (sb.size() == 0) check("R10 rvalid without request", 32'd1, 32'd0);
      else begin
        it = sb.pop_front();
        check("R1/R2/R3/R7 rdata", rdata, it.d);
        check("R2 sec_err", {31'd0, sec_err}, {31'd0, it.s});
        check("R3 ded_err", {31'd0, ded_err}, {31'd0, it.e});
        check("R2/R3 irq", {31'd0, irq}, {31'd0, it.s | it.e});
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic p);
    @(negedge clk);
    req = 1; we = 1; addr = AW'(a); wdata = d; prot_en = p;
    @(negedge clk);
    req = 0; we = 0;
    check("R10 no rvalid after write", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic rd(input int a, input logic p, input logic [31:0] d, input logic s, input logic e);
    item_t it;
    @(negedge clk);
    req = 1; we = 0; addr = AW'(a); prot_en = p;
    it.d = d; it.s = s; it.e = e;
    sb.push_back(it);
    if (s) begin exp_sc = (exp_sc == CMAX) ? CMAX : exp_sc + 1; exp_sa = a; end
    if (e) begin exp_dc = (exp_dc == CMAX) ? CMAX : exp_dc + 1; exp_da = a; end
    @(negedge clk);
    req = 0;
    check("R4/R5 sec_cnt", 32'(sec_cnt), 32'(exp_sc));
    check("R4 ded_cnt", 32'(ded_cnt), 32'(exp_dc));
    check("R9 sec_addr", 32'(sec_addr), 32'(exp_sa));
    check("R9 ded_addr", 32'(ded_addr), 32'(exp_da));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset sec_cnt", 32'(sec_cnt), 32'd0);
    check("R8 reset ded_cnt", 32'(ded_cnt), 32'd0);
    check("R10 reset rvalid", {31'd0, rvalid}, 32'd0);
    rst_n = 1;
    // R1 clean patterns
    wr(0, 32'h0000_0000, 1); wr(1, 32'hFFFF_FFFF, 1); wr(2, 32'hA5C3_0F96, 1);
    rd(0, 1, 32'h0000_0000, 0, 0);
    rd(1, 1, 32'hFFFF_FFFF, 0, 0);
    rd(2, 1, 32'hA5C3_0F96, 0, 0);
    // R2 and R6: single-bit faults planted through unprotected writes
    wr(3, 32'h1234_5678, 1); wr(3, 32'h1234_5678 ^ 32'h20, 0);
    rd(3, 1, 32'h1234_5678, 1, 0);
    wr(4, 32'hDEAD_BEEF, 1); wr(4, 32'hDEAD_BEEE, 0);
    rd(4, 1, 32'hDEAD_BEEF, 1, 0);
    wr(5, 32'h0F0F_0F0F, 1); wr(5, 32'h8F0F_0F0F, 0);
    rd(5, 1, 32'h0F0F_0F0F, 1, 0);
    // R3: double-bit faults
    wr(6, 32'hCAFE_F00D, 1); wr(6, 32'hCAFE_F00D ^ 32'h0002_0004, 0);
    rd(6, 1, 32'hCAFE_F00D ^ 32'h0002_0004, 0, 1);
    wr(7, 32'h5555_AAAA, 1); wr(7, 32'h5555_AAAA ^ 32'h8000_0001, 0);
    rd(7, 1, 32'h5555_AAAA ^ 32'h8000_0001, 0, 1);
    // R7: bypassed reads return raw bits, counters unchanged
    rd(3, 0, 32'h1234_5658, 0, 0);
    rd(6, 0, 32'hCAFE_F00D ^ 32'h0002_0004, 0, 0);
    // R5: saturate the one-bit counter
    for (int i = 0; i < 16; i++) rd(4, 1, 32'hDEAD_BEEF, 1, 0);
    check("R5 sec_cnt saturated", 32'(sec_cnt), 32'(CMAX));
    // R8: clear
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    exp_sc = 0; exp_dc = 0; exp_sa = 0; exp_da = 0;
    check("R8 clr sec_cnt", 32'(sec_cnt), 32'd0);
    check("R8 clr ded_cnt", 32'(ded_cnt), 32'd0);
    check("R8 clr sec_addr", 32'(sec_addr), 32'd0);
    check("R8 clr ded_addr", 32'(ded_addr), 32'd0);
    // R1: protected rewrite repairs check bits
    wr(6, 32'h1357_9BDF, 1);
    rd(6, 1, 32'h1357_9BDF, 0, 0);
    rd(7, 1, 32'h5555_AAAA ^ 32'h8000_0001, 0, 1);
    repeat (2) @(negedge clk);
    check("R10 scoreboard drained", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule